// File: doc/BRIEF.md
# Configurable-Frame Serial Transmitter

This block turns bytes written by software into asynchronous serial frames on a single line. A line-control register selects the number of data bits (5 to 8), whether a parity bit is sent and what it carries, how long the stop period lasts, and a break override that holds the line low. Each frame is timed by a baud-tick input that pulses at sixteen times the bit rate. The divisor that makes this tick is generated outside the block.

Software writes a byte into a transmit holding register through a small write port. The shifter takes the byte as soon as it is free, and the holding register becomes available again at that point. A second byte written while a frame is on the line waits in the holding register and follows with no idle gap. An empty flag tells software when another byte may be written. Both registers can be read back through a combinational read port.

Top module: `serial_tx_engine`

## Requirements
- R1: Control bits [1:0] select the data length: 00 sends 5 data bits, 01 sends 6, 10 sends 7 and 11 sends 8. Data is sent LSB first.
- R2: After reset the line idles high. A frame starts with one low start bit. Every start, data and parity bit lasts 16 baud ticks.
- R3: A parity bit follows the data only when control bit 3 is set. With control bit 4 set, the parity makes the count of ones over data plus parity even. With control bit 4 clear, that count is odd.
- R4: When control bits 5 and 3 are both set, the parity bit is fixed at the value of control bit 4.
- R5: The stop period is high. It lasts 16 ticks when control bit 2 is clear. With bit 2 set, it lasts 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words.
- R6: While control bit 6 is set, the line is low from the cycle after the write that sets it. Clearing the bit restores the normal line level, and the frame timing runs on underneath the override.
- R7: holdEmpty is 1 after reset. It drops in the cycle after a write to address 0 and rises again in the cycle after the shifter takes the byte. An idle shifter takes a byte one clock after the byte is written.
- R8: A byte written during a frame is held. It is loaded on the clock that ends the last stop tick, so its start bit follows the stop period directly.
- R9: When a write to address 0 falls in the same cycle as a load, the load takes the earlier byte, the new byte stays held, and holdEmpty stays 0.
- R10: Reset clears the control register to 0. rdData returns the control register when rdAddr is 1 and the last byte written to address 0 when rdAddr is 0. Control bit 7 reads back but has no effect.
- R11: Data length, parity and stop settings are captured when a byte is loaded. Changing them during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | One-cycle pulse at 16x the bit rate |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 1 | Write target: 0 holding register, 1 control register |
| wrData | input | 8 | Write data |
| rdAddr | input | 1 | Read select: 0 holding register, 1 control register |
| rdData | output | 8 | Read data |
| txOut | output | 1 | Serial line |
| holdEmpty | output | 1 | Holding register has no pending byte |

## Verification
Two events can land on the same clock edge: the shifter taking the held byte, and software writing a new byte into the holding register. The bench causes this in two ways. It writes two bytes on consecutive cycles into an idle block, and it times a write to the last tick of a stop period. A behavioural model built from segment queues then checks which byte goes out first and that the empty flag stays low. A break set and cleared during a frame is also checked against that model on every cycle, so that the frame timing under the override is verified too.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } txPhase_e;

  // Frame settings the sequencer needs to count bits and stop ticks
  typedef struct packed {
    logic [1:0] wordLen;
    logic       stopSel;
    logic       parEn;
  } frameShape_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     load;
    logic     shift;
    txPhase_e phase;
  } txStrobe_t;

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        baudTick,
  input  logic        holdFull,
  input  frameShape_t liveShape,
  output txStrobe_t   strb
);

  localparam int CNT_W = $clog2(2 * OVERSAMPLE + 1);
  localparam logic [CNT_W-1:0] BIT_T  = CNT_W'(OVERSAMPLE);
  localparam logic [CNT_W-1:0] HALF_T = CNT_W'(OVERSAMPLE / 2);

  txPhase_e          state, stateNxt;
  logic [CNT_W-1:0]  cnt, cntNxt, lim, stopTicks;
  logic [2:0]        bitIdx, bitIdxNxt, lastIdx;
  frameShape_t       shapeLat;
  logic              bitEnd, loadS, shiftS;

  assign lastIdx = 3'd4 + {1'b0, shapeLat.wordLen};

  always_comb begin
    stopTicks = BIT_T;
    if (shapeLat.stopSel) begin
      stopTicks = (shapeLat.wordLen == 2'b00) ? (BIT_T + HALF_T) : (BIT_T + BIT_T);
    end
    lim    = (state == PH_STOP) ? stopTicks : BIT_T;
    bitEnd = baudTick && (cnt == lim - 1'b1);
  end

  always_comb begin
    stateNxt  = state;
    cntNxt    = cnt;
    bitIdxNxt = bitIdx;
    loadS     = 1'b0;
    shiftS    = 1'b0;
    if (state != PH_IDLE && baudTick) begin
      cntNxt = bitEnd ? '0 : cnt + 1'b1;
    end
    case (state)
      PH_IDLE: begin
        if (holdFull) begin
          loadS    = 1'b1;
          stateNxt = PH_START;
          cntNxt   = '0;
        end
      end
      PH_START: begin
        if (bitEnd) begin
          stateNxt  = PH_DATA;
          bitIdxNxt = '0;
        end
      end
      PH_DATA: begin
        if (bitEnd) begin
          shiftS = 1'b1;
          if (bitIdx == lastIdx) begin
            stateNxt = shapeLat.parEn ? PH_PARITY : PH_STOP;
          end else begin
            bitIdxNxt = bitIdx + 1'b1;
          end
        end
      end
      PH_PARITY: begin
        if (bitEnd) stateNxt = PH_STOP;
      end
      PH_STOP: begin
        if (bitEnd) begin
          if (holdFull) begin
            loadS    = 1'b1;
            stateNxt = PH_START;
          end else begin
            stateNxt = PH_IDLE;
          end
        end
      end
      default: stateNxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      shapeLat <= '0;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      bitIdx <= bitIdxNxt;
      if (loadS) shapeLat <= liveShape;
    end
  end

  always_comb begin
    strb.load  = loadS;
    strb.shift = shiftS;
    strb.phase = state;
  end

  // Bit index never passes the captured word length (R1)
  assert_bitidx_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_DATA) |-> (bitIdx <= lastIdx));

  // Tick counter stays inside the current bit's length (R2, R5)
  assert_tick_count_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PH_IDLE) |-> (cnt < lim));

  // Parity phase only for frames captured with parity on (R3)
  assert_parity_phase_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_PARITY) |-> shapeLat.parEn);

  // Stop period ending without a pending byte returns to idle (R8)
  assert_stop_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_STOP && bitEnd && !holdFull) |=> (state == PH_IDLE));

endmodule

// File: rtl/sertx_dpath.sv
module sertx_dpath
  import sertx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic        wrAddr,
  input  logic [7:0]  wrData,
  input  logic        rdAddr,
  input  txStrobe_t   strb,
  output logic [7:0]  rdData,
  output logic        txOut,
  output logic        holdEmpty,
  output logic        holdFull,
  output frameShape_t liveShape
);

  localparam int BRK_BIT   = 6;
  localparam int STICK_BIT = 5;
  localparam int EVEN_BIT  = 4;

  logic [7:0] ctrlReg, holdReg, shifter, dataMask;
  logic       parBit, parNxt, onesOdd, lineBit, wrHold, wrCtrl;

  assign wrHold = wrEn && !wrAddr;
  assign wrCtrl = wrEn && wrAddr;

  assign liveShape.wordLen = ctrlReg[1:0];
  assign liveShape.stopSel = ctrlReg[2];
  assign liveShape.parEn   = ctrlReg[3];

  assign dataMask = 8'hFF >> (2'd3 - ctrlReg[1:0]);
  assign onesOdd  = ^(holdReg & dataMask);

  always_comb begin
    if (ctrlReg[STICK_BIT]) parNxt = ctrlReg[EVEN_BIT];
    else if (ctrlReg[EVEN_BIT]) parNxt = onesOdd;
    else parNxt = ~onesOdd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg  <= '0;
      holdReg  <= '0;
      holdFull <= 1'b0;
      shifter  <= '0;
      parBit   <= 1'b0;
    end else begin
      if (wrCtrl) ctrlReg <= wrData;
      if (wrHold) begin
        holdReg  <= wrData;
        holdFull <= 1'b1;
      end else if (strb.load) begin
        holdFull <= 1'b0;
      end
      if (strb.load) begin
        shifter <= holdReg;
        parBit  <= parNxt;
      end else if (strb.shift) begin
        shifter <= shifter >> 1;
      end
    end
  end

  always_comb begin
    case (strb.phase)
      PH_START:  lineBit = 1'b0;
      PH_DATA:   lineBit = shifter[0];
      PH_PARITY: lineBit = parBit;
      default:   lineBit = 1'b1;
    endcase
  end

  assign txOut     = ctrlReg[BRK_BIT] ? 1'b0 : lineBit;
  assign holdEmpty = !holdFull;
  assign rdData    = rdAddr ? ctrlReg : holdReg;

  // The sequencer only loads when a byte is waiting (R7)
  assert_load_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |-> holdFull);

  // A write to the holding register clears the empty flag (R7)
  assert_write_clears_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrHold |=> !holdEmpty);

  // Load and write in one cycle keeps the new byte pending (R9)
  assert_collision_keeps_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && wrHold) |=> (holdFull && holdReg == $past(wrData)));

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import sertx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baudTick,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [7:0] wrData,
  input  logic       rdAddr,
  output logic [7:0] rdData,
  output logic       txOut,
  output logic       holdEmpty
);

  txStrobe_t   strb;
  frameShape_t liveShape;
  logic        holdFull;

  sertx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .baudTick  (baudTick),
    .holdFull  (holdFull),
    .liveShape (liveShape),
    .strb      (strb)
  );

  sertx_dpath u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .strb      (strb),
    .rdData    (rdData),
    .txOut     (txOut),
    .holdEmpty (holdEmpty),
    .holdFull  (holdFull),
    .liveShape (liveShape)
  );

endmodule

// File: tb/serial_tx_engine_bench.sv
module serial_tx_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baudTick = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrAddr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdAddr = 1'b0;
  logic [7:0] rdData;
  logic       txOut;
  logic       holdEmpty;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R10";
  bit    done = 0;

  // reference model state
  int   segLvl[$];
  int   segTicks[$];
  bit   mHoldFull = 0;
  logic [7:0] mHoldData = 0;
  logic [7:0] mCtrl = 0;

  always #5 clk = ~clk;

  serial_tx_engine u_serial_tx_engine (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .txOut(txOut), .holdEmpty(holdEmpty)
  );

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  task automatic buildFrame(logic [7:0] d, logic [7:0] c);
    int nb = 5 + int'(c[1:0]);
    int ones = 0;
    int par;
    segLvl.push_back(0); segTicks.push_back(16);
    for (int i = 0; i < nb; i++) begin
      segLvl.push_back(int'(d[i])); segTicks.push_back(16);
      ones += int'(d[i]);
    end
    if (c[3]) begin
      if (c[5]) par = int'(c[4]);
      else if (c[4]) par = ones % 2;
      else par = 1 - (ones % 2);
      segLvl.push_back(par); segTicks.push_back(16);
    end
    segLvl.push_back(1);
    if (!c[2]) segTicks.push_back(16);
    else if (c[1:0] == 2'b00) segTicks.push_back(24);
    else segTicks.push_back(32);
  endtask

  // model step and comparison every clock
  always @(posedge clk) begin
    bit doLoad;
    int expTx;
    if (!rst_n) begin
      segLvl.delete(); segTicks.delete();
      mHoldFull = 0; mHoldData = 0; mCtrl = 0;
    end else begin
      doLoad = 0;
      if (segLvl.size() == 0) begin
        if (mHoldFull) doLoad = 1;
      end else if (baudTick) begin
        segTicks[0] = segTicks[0] - 1;
        if (segTicks[0] == 0) begin
          void'(segLvl.pop_front()); void'(segTicks.pop_front());
          if (segLvl.size() == 0 && mHoldFull) doLoad = 1;
        end
      end
      if (doLoad) begin
        buildFrame(mHoldData, mCtrl);
        mHoldFull = 0;
      end
      if (wrEn && !wrAddr) begin mHoldFull = 1; mHoldData = wrData; end
      if (wrEn && wrAddr) mCtrl = wrData;
    end
    #1;
    if (mCtrl[6]) expTx = 0;
    else if (segLvl.size() == 0) expTx = 1;
    else expTx = segLvl[0];
    chk(curReq, "txOut", int'(txOut), expTx);
    chk(curReq, "holdEmpty", int'(holdEmpty), int'(!mHoldFull));
    chk(curReq, "rdData", int'(rdData), rdAddr ? int'(mCtrl) : int'(mHoldData));
  end

  // baud tick every third clock
  initial begin
    int tdiv = 0;
    forever begin
      @(negedge clk);
      baudTick = (tdiv == 2);
      tdiv = (tdiv + 1) % 3;
    end
  end

  task automatic writeReg(logic a, logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic waitDone();
    while (segLvl.size() != 0 || mHoldFull) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sendCfg(logic [7:0] c, logic [7:0] d);
    writeReg(1'b1, c);
    writeReg(1'b0, d);
    waitDone();
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10 reset state: idle high line, empty flag, cleared control register
    rdAddr = 1;
    #1;
    chk("R10", "reset txOut", int'(txOut), 1);
    chk("R2", "reset idle line", int'(txOut), 1);
    chk("R7", "reset holdEmpty", int'(holdEmpty), 1);
    chk("R10", "reset control", int'(rdData), 0);
    rdAddr = 0;
    @(negedge clk); rst_n = 1;

    curReq = "R2";  sendCfg(8'h03, 8'hA5);
    curReq = "R1";  sendCfg(8'h00, 8'h1B);
    sendCfg(8'h01, 8'h2E);
    sendCfg(8'h02, 8'h6C);
    curReq = "R3";  sendCfg(8'h19, 8'h07);
    sendCfg(8'h0A, 8'h55);
    sendCfg(8'h0B, 8'h80);
    curReq = "R4";  sendCfg(8'h3B, 8'h01);
    sendCfg(8'h2B, 8'hFF);
    curReq = "R5";  sendCfg(8'h04, 8'h15);
    sendCfg(8'h07, 8'h81);
    sendCfg(8'h06, 8'h3C);
    curReq = "R7";  sendCfg(8'h03, 8'hC3);

    // R8 byte written mid-frame follows back to back
    curReq = "R8";
    writeReg(1'b1, 8'h03);
    writeReg(1'b0, 8'h11);
    repeat (100) @(negedge clk);
    writeReg(1'b0, 8'h22);
    waitDone();

    // R9 write in the load cycle of an idle block
    curReq = "R9";
    @(negedge clk); wrEn = 1; wrAddr = 0; wrData = 8'h3A;
    @(negedge clk); wrData = 8'hC5;
    @(negedge clk); wrEn = 0;
    #1;
    chk("R9", "holdEmpty after collision", int'(holdEmpty), 0);
    // R9 write on the last stop tick of a frame
    while (!(segLvl.size() == 1 && segTicks[0] == 1 && mHoldFull == 0)) @(negedge clk);
    while (baudTick != 1) begin
      @(negedge clk);
      if (segLvl.size() != 1) break;
    end
    wrEn = 1; wrAddr = 0; wrData = 8'h5E;
    @(negedge clk); wrEn = 0;
    waitDone();

    // R11 settings changed mid-frame apply only to the next frame
    curReq = "R11";
    writeReg(1'b1, 8'h03);
    writeReg(1'b0, 8'h5A);
    repeat (60) @(negedge clk);
    writeReg(1'b1, 8'h0C);
    waitDone();
    writeReg(1'b0, 8'h5A);
    waitDone();

    // R6 break during a frame and at idle
    curReq = "R6";
    writeReg(1'b1, 8'h03);
    writeReg(1'b0, 8'h99);
    repeat (80) @(negedge clk);
    writeReg(1'b1, 8'h43);
    #1;
    chk("R6", "break forces low", int'(txOut), 0);
    repeat (50) @(negedge clk);
    writeReg(1'b1, 8'h03);
    waitDone();
    writeReg(1'b1, 8'h40);
    repeat (10) @(negedge clk);
    #1;
    chk("R6", "break at idle", int'(txOut), 0);
    writeReg(1'b1, 8'h00);
    #1;
    chk("R6", "break released", int'(txOut), 1);

    // R10 readback of both registers, bit 7 without effect
    curReq = "R10";
    rdAddr = 1;
    writeReg(1'b1, 8'h83);
    writeReg(1'b0, 8'h96);
    repeat (40) @(negedge clk);
    rdAddr = 0;
    waitDone();
    #1;
    chk("R10", "holding readback", int'(rdData), 8'h96);

    done = 1;
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule